// File: doc/BRIEF.md
# Four-Dimensional Strided Tensor Address Walker

This block turns a compact four-dimensional access pattern into a stream of byte addresses, one per tensor element. A pattern gives a 32-bit start address, a signed element stride for each of four dimensions and an unsigned element count for each dimension. Together with a data-type code, which fixes the element width at 1, 2 or 4 bytes, the block walks every element with dimension 0 as the fastest loop. It presents each address on a valid/ready stream and flags the final element.

A copy or cast engine uses two instances, one for the source tensor and one for the destination tensor. Each instance also reports the product of its four counts, so the engine can check that both tensors hold the same number of elements. Addresses are built with adders only. A per-dimension run pointer records where the current pass through that dimension began, so a carry reloads lower dimensions from that pointer and no multiplication is needed.

Top module: `tensor_walk4d`

## Requirements
- R1: After reset, valid_o, done_o and busy_o are 0 and total_o is 0.
- R2: A start_i high at a clock edge while idle latches the pattern and type code. When every count is non-zero, valid_o rises at that edge and the first address equals base_i.
- R3: Beat n carries base + size × Σ idx_d × stride_d, modulo 2^32. The indices idx_d come from n with dimension 0 changing fastest and dimension 3 slowest (idx_0 = n mod count_0, and so on).
- R4: The element size is taken from dtype_i: codes 0x2, 0x3, 0xD, 0xE and 0xF give 1 byte; codes 0x4 to 0x7 give 2 bytes; codes 0x8 to 0xB give 4 bytes; any other code gives 1 byte.
- R5: Strides are two's-complement, so negative and zero strides move the address backwards or leave it in place. An address that passes 0xFFFFFFFF wraps around.
- R6: On each accepted start, total_o takes the product of the four counts and holds that value until the next accepted start.
- R7: If any count is zero, the block emits no beat and raises done_o for one cycle on the edge after the start. total_o becomes 0.
- R8: While valid_o is high and ready_i is low, addr_o, last_o and valid_o keep their values into the next cycle.
- R9: last_o is high on the final beat of a walk and low on every other beat.
- R10: After the edge that accepts the final beat, done_o is high for exactly one cycle, valid_o is low and busy_o is low.
- R11: A start_i that arrives while a walk is in progress is ignored. The address sequence and total_o continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk with the pattern presented on the same cycle |
| base_i | input | 32 | Start byte address |
| stride_i | input | 64 | Four signed 16-bit element strides, dimension d at bits [16d+15:16d] |
| count_i | input | 64 | Four unsigned 16-bit element counts, dimension d at bits [16d+15:16d] |
| dtype_i | input | 4 | Data-type code that selects the element size |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse when a walk finishes or an empty pattern is seen |
| total_o | output | 64 | Product of the four counts of the latched pattern |
| valid_o | output | 1 | addr_o holds an element address |
| ready_i | input | 1 | Consumer accepts the current address |
| addr_o | output | 32 | Byte address of the current element |
| last_o | output | 1 | Current element is the final one |

## Verification
The bench aims at carries that ripple through several dimensions at once. If the run pointers were reloaded wrongly, the addresses after the first wrap of dimension 0 would drift. Negative strides and a start address near the top of the address space check sign extension and wrap-around; a block that zero-extended the stride would jump forward by almost 64 KiB of elements. The bench also checks the type-code table, including codes outside the table, a count of zero, which a careless block would turn into a 65536-long walk, and a single-element tensor that must set last on its only beat. Random back-pressure verifies that a stalled beat is neither skipped nor repeated. A start issued mid-walk must not disturb the sequence or the total.

// File: rtl/twk_pkg.sv
package twk_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

  // log2 of element size in bytes, derived from the data-type code
  function automatic logic [1:0] elem_shift(input logic [3:0] code);
    logic [1:0] sh;
    case (code)
      4'h4, 4'h5, 4'h6, 4'h7: sh = 2'd1;
      4'h8, 4'h9, 4'hA, 4'hB: sh = 2'd2;
      default:                sh = 2'd0;
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/twk_index_ctr.sv
module twk_index_ctr #(
  parameter int NDIM = 4,
  parameter int CW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               load,
  input  logic               step,
  input  logic [NDIM*CW-1:0] cnt_flat,
  output logic [NDIM-1:0]    at_max,
  output logic [NDIM-1:0]    adv_dim,
  output logic [NDIM-1:0]    upd_dim,
  output logic               final_elem
);

  logic [CW-1:0] idx [NDIM];
  logic [NDIM:0] low_all;

  assign low_all[0] = 1'b1;

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    logic [CW-1:0] cnt_d;
    assign cnt_d      = cnt_flat[d*CW +: CW];
    assign at_max[d]  = (idx[d] == cnt_d - 1'b1);
    assign low_all[d+1] = low_all[d] & at_max[d];
    assign upd_dim[d] = low_all[d];
    assign adv_dim[d] = low_all[d] & ~at_max[d];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx[d] <= '0;
      end else if (load) begin
        idx[d] <= '0;
      end else if (step && !final_elem && upd_dim[d]) begin
        idx[d] <= at_max[d] ? '0 : idx[d] + 1'b1;
      end
    end

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (idx[d] < cnt_d));
  end

  assign final_elem = low_all[NDIM];

  // R3
  adv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($onehot0(adv_dim) && (final_elem || $countones(adv_dim) == 1)));

endmodule

// File: rtl/twk_addr_gen.sv
module twk_addr_gen #(
  parameter int NDIM = 4,
  parameter int AW   = 32,
  parameter int SW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [AW-1:0]      base,
  input  logic               step,
  input  logic [NDIM-1:0]    upd_dim,
  input  logic [NDIM-1:0]    adv_dim,
  input  logic [NDIM*SW-1:0] stride_flat,
  input  logic [1:0]         shift,
  output logic [AW-1:0]      addr
);

  logic [AW-1:0] ptr  [NDIM];
  logic [AW-1:0] sb   [NDIM];
  logic [AW-1:0] cand [NDIM];
  logic [AW-1:0] next_addr;

  for (genvar d = 0; d < NDIM; d++) begin : g_ptr
    logic [SW-1:0] s_d;
    assign s_d     = stride_flat[d*SW +: SW];
    assign sb[d]   = {{(AW-SW){s_d[SW-1]}}, s_d} << shift;
    assign cand[d] = ptr[d] + sb[d];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr[d] <= '0;
      end else if (load) begin
        ptr[d] <= base;
      end else if (step && upd_dim[d]) begin
        ptr[d] <= next_addr;
      end
    end
  end

  always_comb begin
    next_addr = '0;
    for (int d = 0; d < NDIM; d++) begin
      if (adv_dim[d]) next_addr = next_addr | cand[d];
    end
  end

  assign addr = ptr[0];

  // R3
  inner_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && adv_dim[0] && !load) |=> (addr == $past(addr) + $past(sb[0])));

  // R2
  load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(base)));

endmodule

// File: rtl/tensor_walk4d.sv
module tensor_walk4d #(
  parameter int NDIM = 4,
  parameter int AW   = 32,
  parameter int SW   = 16,
  parameter int CW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [AW-1:0]      base_i,
  input  logic [NDIM*SW-1:0] stride_i,
  input  logic [NDIM*CW-1:0] count_i,
  input  logic [3:0]         dtype_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [NDIM*CW-1:0] total_o,
  output logic               valid_o,
  input  logic               ready_i,
  output logic [AW-1:0]      addr_o,
  output logic               last_o
);
  import twk_pkg::*;

  localparam int TW = NDIM * CW;

  walk_state_e      state_q;
  logic [TW-1:0]    cnt_q;
  logic [NDIM*SW-1:0] stride_q;
  logic [1:0]       shift_q;
  logic [TW-1:0]    total_q;
  logic             done_q;

  logic             accept;
  logic             any_zero;
  logic [TW-1:0]    prod;
  logic             fire;
  logic             load_walk;
  logic [NDIM-1:0]  at_max, adv_dim, upd_dim;
  logic             final_elem;

  always_comb begin
    any_zero = 1'b0;
    prod     = {{(TW-1){1'b0}}, 1'b1};
    for (int d = 0; d < NDIM; d++) begin
      if (count_i[d*CW +: CW] == '0) any_zero = 1'b1;
      prod = TW'(prod * TW'(count_i[d*CW +: CW]));
    end
  end

  assign accept    = start_i && (state_q == WALK_IDLE);
  assign load_walk = accept && !any_zero;
  assign fire      = valid_o && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WALK_IDLE;
      cnt_q    <= '0;
      stride_q <= '0;
      shift_q  <= '0;
      total_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (accept && any_zero) || (fire && final_elem);
      if (accept) begin
        cnt_q    <= count_i;
        stride_q <= stride_i;
        shift_q  <= elem_shift(dtype_i);
        total_q  <= any_zero ? '0 : prod;
      end
      if (load_walk)               state_q <= WALK_RUN;
      else if (fire && final_elem) state_q <= WALK_IDLE;
    end
  end

  twk_index_ctr #(.NDIM(NDIM), .CW(CW)) u_idx (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (valid_o),
    .load       (load_walk),
    .step       (fire),
    .cnt_flat   (cnt_q),
    .at_max     (at_max),
    .adv_dim    (adv_dim),
    .upd_dim    (upd_dim),
    .final_elem (final_elem)
  );

  twk_addr_gen #(.NDIM(NDIM), .AW(AW), .SW(SW)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load_walk),
    .base        (base_i),
    .step        (fire && !final_elem),
    .upd_dim     (upd_dim),
    .adv_dim     (adv_dim),
    .stride_flat (stride_q),
    .shift       (shift_q),
    .addr        (addr_o)
  );

  assign busy_o  = (state_q == WALK_RUN);
  assign valid_o = busy_o;
  assign last_o  = valid_o && final_elem;
  assign done_o  = done_q;
  assign total_o = total_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(last_o)));

  // R10
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_o) |=> (done_o && !valid_o && !busy_o));

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);

  // R7
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_zero) |=> (done_o && !valid_o && total_o == '0));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(total_o));

endmodule

// File: tb/tensor_walk4d_tb.sv
module tensor_walk4d_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [63:0] stride_i;
  logic [63:0] count_i;
  logic [3:0]  dtype_i;
  logic        busy_o, done_o, valid_o, ready_i, last_o;
  logic [63:0] total_o;
  logic [31:0] addr_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tensor_walk4d dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .stride_i(stride_i), .count_i(count_i), .dtype_i(dtype_i),
    .busy_o(busy_o), .done_o(done_o), .total_o(total_o),
    .valid_o(valid_o), .ready_i(ready_i), .addr_o(addr_o), .last_o(last_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int size_of(input logic [3:0] c);
    if (c inside {4'h2, 4'h3, 4'hD, 4'hE, 4'hF}) return 1;
    if (c >= 4'h4 && c <= 4'h7) return 2;
    if (c >= 4'h8 && c <= 4'hB) return 4;
    return 1;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [63:0] s,
                                           input logic [63:0] c, input logic [3:0] code,
                                           input longint n);
    longint rem = n;
    longint acc = 0;
    for (int d = 0; d < 4; d++) begin
      longint cd = longint'(c[d*16 +: 16]);
      longint idx = rem % cd;
      rem = rem / cd;
      acc += idx * longint'($signed(s[d*16 +: 16]));
    end
    return b + 32'(acc * size_of(code));
  endfunction

  function automatic longint prod_of(input logic [63:0] c);
    longint p = 1;
    for (int d = 0; d < 4; d++) p *= longint'(c[d*16 +: 16]);
    return p;
  endfunction

  // Runs one walk; inject=1 issues a second start mid-walk (R11)
  task automatic run_walk(input logic [31:0] b, input logic [63:0] s, input logic [63:0] c,
                          input logic [3:0] code, input bit inject, input int rdy_pct);
    longint total = prod_of(c);
    longint n = 0;
    bit hold = 0;
    logic [31:0] held_a = '0;
    logic held_l = 0;
    @(negedge clk);
    start_i = 1; base_i = b; stride_i = s; count_i = c; dtype_i = code; ready_i = 0;
    @(negedge clk);
    start_i = 0;
    base_i = ~b; stride_i = ~s; count_i = 64'h0001_0001_0001_0001;
    if (total == 0) begin
      chk(done_o == 1 && valid_o == 0, "R7 empty done", {done_o, valid_o}, 2'b10);
      chk(total_o == 0, "R7 total zero", total_o, 0);
      @(negedge clk);
      chk(done_o == 0, "R7 done pulse width", done_o, 0);
      return;
    end
    chk(valid_o == 1, "R2 valid after start", valid_o, 1);
    chk(total_o == 64'(total), "R6 total", total_o, total);
    while (n < total) begin
      logic v = valid_o;
      logic [31:0] a = addr_o;
      logic l = last_o;
      bit r;
      start_i = 0;
      chk(v == 1, "R2 valid during walk", v, 1);
      if (hold) begin
        chk(a == held_a && l == held_l, "R8 hold under stall", a, held_a);
      end
      r = ($urandom_range(0, 99) < rdy_pct);
      ready_i = r;
      if (inject && n == 2) begin
        start_i = 1; base_i = 32'h1234_5678; count_i = 64'h0002_0002_0002_0002;
        stride_i = 64'h1; dtype_i = 4'h8;
      end
      if (v && r) begin
        logic [31:0] e = exp_addr(b, s, c, code, n);
        chk(a == e, inject ? "R11 sequence unchanged" : "R3 address", a, e);
        chk(l == (n == total - 1), "R9 last flag", l, n == total - 1);
        n++;
      end
      hold = v && !r;
      held_a = a; held_l = l;
      @(negedge clk);
    end
    start_i = 0; ready_i = 0;
    chk(done_o == 1 && valid_o == 0 && busy_o == 0, "R10 done after last", {done_o, valid_o, busy_o}, 3'b100);
    chk(total_o == 64'(total), inject ? "R11 total unchanged" : "R6 total held", total_o, total);
    @(negedge clk);
    chk(done_o == 0, "R10 done one cycle", done_o, 0);
  endtask

  function automatic logic [63:0] pack4(input int a, input int b2, input int c2, input int d);
    return {16'(d), 16'(c2), 16'(b2), 16'(a)};
  endfunction

  initial begin
    logic [3:0] codes [13] = '{4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF};
    void'($urandom(32'h0C0FFEE5));
    rst_n = 0; start_i = 0; ready_i = 0; base_i = 0; stride_i = 0; count_i = 0; dtype_i = 0;
    repeat (3) @(negedge clk);
    chk(valid_o == 0 && done_o == 0 && busy_o == 0, "R1 reset outputs", {valid_o, done_o, busy_o}, 0);
    chk(total_o == 0, "R1 reset total", total_o, 0);
    rst_n = 1;
    @(negedge clk);

    // R9 single element
    run_walk(32'h0000_1000, pack4(5, 5, 5, 5), pack4(1, 1, 1, 1), 4'h8, 0, 100);
    // R3 full ready, four-dim carry ripple
    run_walk(32'h0010_0000, pack4(1, 3, 20, 100), pack4(3, 2, 2, 3), 4'h2, 0, 100);
    // R4 each size class and an out-of-table code
    run_walk(32'h0000_2000, pack4(1, 4, 0, 0), pack4(4, 2, 1, 1), 4'h6, 0, 70);
    run_walk(32'h0000_2000, pack4(1, 4, 0, 0), pack4(4, 2, 1, 1), 4'hB, 0, 70);
    run_walk(32'h0000_2000, pack4(1, 4, 0, 0), pack4(4, 2, 1, 1), 4'hC, 0, 70);
    // R5 negative strides and wrap
    run_walk(32'h0000_0008, pack4(-1, -7, 0, 3), pack4(5, 3, 2, 2), 4'h9, 0, 50);
    run_walk(32'hFFFF_FFF0, pack4(3, 16, -2, 1), pack4(4, 3, 2, 2), 4'h4, 0, 60);
    // R7 zero count in each position
    for (int d = 0; d < 4; d++) begin
      logic [63:0] c = pack4(2, 2, 2, 2);
      c[d*16 +: 16] = 16'h0;
      run_walk(32'h0000_3000, pack4(1, 1, 1, 1), c, 4'h2, 0, 100);
    end
    // R11 start while busy
    run_walk(32'h0000_4000, pack4(2, 9, -4, 50), pack4(3, 3, 2, 2), 4'h5, 1, 60);
    // constrained random
    for (int t = 0; t < 40; t++) begin
      logic [63:0] s, c;
      for (int d = 0; d < 4; d++) begin
        s[d*16 +: 16] = 16'($signed($urandom_range(0, 600)) - 300);
        c[d*16 +: 16] = 16'($urandom_range(1, 4));
      end
      run_walk($urandom, s, c, ($urandom_range(0, 9) == 0) ? 4'h1 : codes[$urandom_range(0, 12)],
               0, $urandom_range(30, 100));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule